// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of an 8-bit flash memory bus. It watches address, data and an active-low write strobe. It recognises the multi-cycle command sequences that start a chip erase, a sector erase or a byte program. A bus write is taken when the strobe returns high. Two unlock writes open every sequence. A program sequence ends with one more command write and then the target address and byte. An erase sequence sends a setup command, repeats the unlock pair, and ends with a chip-erase or sector-erase data write.

After a sector-erase data write, an acceptance window runs for a parameterised number of clocks. Each further sector-erase data write inside the window adds a sector and restarts the window. Sectors are kept as a bitmap with one bit per sector. When the window runs out, the block sends one start request to the erase/program engine, along with the operation code and the sector bitmap. While that engine is working, every bus write is ignored. A done pulse from the engine returns the block to read mode. An asynchronous active-low hardware reset abandons any partial sequence, open window or running operation.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Immediately after reset `read_mode` is 1, `eng_start` is 0 and `start_sect_map` is all zeros.
- R2: The write sequence AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 (hex data @ hex address, compared on address bits [10:0] only) causes one `eng_start` pulse with `start_op` = 2 (chip erase) and every bit of `start_sect_map` set. This happens in the cycle after the clock edge that sees the last write.
- R3: When the sixth write of the same prefix carries data 0x30 at any address, sector number bus_addr[17:15] is marked in `start_sect_map`. The start pulse with `start_op` = 3 (sector erase) follows WIN_CYC clocks after the edge that took that write, provided no further write arrives.
- R4: A data-0x30 write during the window sets that write's sector bit and restarts the full WIN_CYC window from its edge.
- R5: A sector named more than once in one sequence occupies a single bitmap bit.
- R6: A write that does not match the expected address/data for the current step, or a write other than data 0x30 during the window, returns the block to read mode with an empty bitmap and no start pulse.
- R7: Between a start pulse and the engine's `eng_done` pulse, `read_mode` is 0 and bus writes cause no start. `eng_done` returns the block to read mode with the bitmap cleared.
- R8: Asserting `rst_n` low during a partial sequence, an open window or a running operation returns the block to the R1 state, and no start is issued for the abandoned sequence.
- R9: AA@555, 55@2AA, A0@555 followed by any write gives one start pulse with `start_op` = 1 (program), `start_addr` and `start_data` equal to that last write's address and data.
- R10: `eng_start` is high for exactly one clock per accepted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | 18 | Bus write address |
| bus_data | input | 8 | Bus write data |
| bus_we_n | input | 1 | Active-low write strobe; write taken on its rising edge |
| eng_done | input | 1 | Engine finished pulse |
| read_mode | output | 1 | Decoder idle in read mode |
| eng_start | output | 1 | One-clock start request to the engine |
| start_op | output | 2 | 1 program, 2 chip erase, 3 sector erase |
| start_sect_map | output | 8 | Sectors selected for erase, one bit each |
| start_addr | output | 18 | Program target address |
| start_data | output | 8 | Program byte |

## Verification
The hardest state to reach is a window that is extended several times and ends with a duplicate sector. Each extra write must land before the timer expires but after earlier writes have reloaded it. The stimulus sends three further sector writes about three clocks apart, one of them repeating an earlier sector, and then leaves the bus quiet. The reference model then predicts the exact clock of the start pulse. Resets that arrive inside the window and during the engine's run are also driven, to show that nothing leaks out afterwards.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_PROG = 2'd1,
      OP_CHIP = 2'd2,
      OP_SECT = 2'd3
   } fop_e;

   typedef enum logic [3:0] {
      ST_READ,
      ST_UNL1,
      ST_UNL2,
      ST_ERS3,
      ST_ERS4,
      ST_ERS5,
      ST_PGM,
      ST_WIN,
      ST_BUSY
   } fst_e;

   typedef struct packed {
      logic unl_a;
      logic unl_b;
      logic cmd_erase;
      logic cmd_prog;
      logic dat_chip;
      logic dat_sect;
   } cyc_class_t;

   localparam logic [10:0] ADR_KEY_A  = 11'h555;
   localparam logic [10:0] ADR_KEY_B  = 11'h2AA;
   localparam logic [7:0]  DAT_KEY_A  = 8'hAA;
   localparam logic [7:0]  DAT_KEY_B  = 8'h55;
   localparam logic [7:0]  DAT_ERASE  = 8'h80;
   localparam logic [7:0]  DAT_PROG   = 8'hA0;
   localparam logic [7:0]  DAT_CHIP   = 8'h10;
   localparam logic [7:0]  DAT_SECT   = 8'h30;

endpackage

// File: rtl/fcd_wr_strobe.sv
module fcd_wr_strobe #(
   parameter bit RISE_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_we_n,
   output logic wr_evt
);
   logic we_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_prev_q <= 1'b1;
      else        we_prev_q <= bus_we_n;
   end

   generate
      if (RISE_EDGE) begin : g_rise
         assign wr_evt = bus_we_n & ~we_prev_q;
      end else begin : g_fall
         assign wr_evt = ~bus_we_n & we_prev_q;
      end
   endgenerate

endmodule

// File: rtl/fcd_classify.sv
module fcd_classify
   import flash_cmd_pkg::*;
#(
   parameter int CMP_W = 11
) (
   input  logic [CMP_W-1:0] cmp_addr,
   input  logic [7:0]       wr_data,
   output cyc_class_t       cls
);
   logic at_a, at_b;

   generate
      if (CMP_W != 11) begin : g_bad_cmp
         $error("fcd_classify: CMP_W must be 11");
      end
   endgenerate

   always_comb begin
      at_a          = (cmp_addr == ADR_KEY_A);
      at_b          = (cmp_addr == ADR_KEY_B);
      cls.unl_a     = at_a && (wr_data == DAT_KEY_A);
      cls.unl_b     = at_b && (wr_data == DAT_KEY_B);
      cls.cmd_erase = at_a && (wr_data == DAT_ERASE);
      cls.cmd_prog  = at_a && (wr_data == DAT_PROG);
      cls.dat_chip  = at_a && (wr_data == DAT_CHIP);
      cls.dat_sect  = (wr_data == DAT_SECT);
   end

endmodule

// File: rtl/fcd_sector_buf.sv
module fcd_sector_buf #(
   parameter int NUM_SECT = 8,
   parameter int SECT_W   = 3,
   parameter int WIN_CYC  = 2500
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                set_all,
   input  logic                add_en,
   input  logic [SECT_W-1:0]   add_idx,
   input  logic                win_load,
   input  logic                win_run,
   output logic [NUM_SECT-1:0] map,
   output logic                win_expire
);
   localparam int TMR_W = $clog2(WIN_CYC);
   localparam logic [TMR_W-1:0] TMR_TOP = TMR_W'(WIN_CYC - 1);

   logic [TMR_W-1:0] tmr_q;

   generate
      for (genvar g = 0; g < NUM_SECT; g++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                       map[g] <= 1'b0;
            else if (clr)                                     map[g] <= 1'b0;
            else if (set_all)                                 map[g] <= 1'b1;
            else if (add_en && (add_idx == SECT_W'(g)))       map[g] <= 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        tmr_q <= '0;
      else if (win_load)                 tmr_q <= TMR_TOP;
      else if (win_run && tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
   end

   assign win_expire = win_run && (tmr_q == '0);

   p_tmr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_q <= TMR_TOP);

   p_map_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr) |=> ((map & $past(map)) == $past(map)));

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_evt,
   input  cyc_class_t        cls,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              eng_done,
   input  logic              win_expire,
   output fst_e              st_q,
   output logic              clr,
   output logic              set_all,
   output logic              add_en,
   output logic              win_load,
   output logic              win_run,
   output logic              start_req_q,
   output fop_e              op_q,
   output logic [ADDR_W-1:0] pg_addr_q,
   output logic [7:0]        pg_data_q
);
   fst_e nxt;
   logic go, cap_pgm;
   fop_e go_op;

   always_comb begin
      nxt      = st_q;
      set_all  = 1'b0;
      add_en   = 1'b0;
      win_load = 1'b0;
      go       = 1'b0;
      go_op    = OP_NONE;
      cap_pgm  = 1'b0;
      unique case (st_q)
         ST_READ: if (wr_evt) nxt = cls.unl_a ? ST_UNL1 : ST_READ;
         ST_UNL1: if (wr_evt) nxt = cls.unl_b ? ST_UNL2 : ST_READ;
         ST_UNL2: if (wr_evt) begin
            if (cls.cmd_erase)     nxt = ST_ERS3;
            else if (cls.cmd_prog) nxt = ST_PGM;
            else                   nxt = ST_READ;
         end
         ST_ERS3: if (wr_evt) nxt = cls.unl_a ? ST_ERS4 : ST_READ;
         ST_ERS4: if (wr_evt) nxt = cls.unl_b ? ST_ERS5 : ST_READ;
         ST_ERS5: if (wr_evt) begin
            if (cls.dat_chip) begin
               set_all = 1'b1;
               go      = 1'b1;
               go_op   = OP_CHIP;
               nxt     = ST_BUSY;
            end else if (cls.dat_sect) begin
               add_en   = 1'b1;
               win_load = 1'b1;
               nxt      = ST_WIN;
            end else begin
               nxt = ST_READ;
            end
         end
         ST_PGM: if (wr_evt) begin
            cap_pgm = 1'b1;
            go      = 1'b1;
            go_op   = OP_PROG;
            nxt     = ST_BUSY;
         end
         ST_WIN: begin
            if (wr_evt) begin
               if (cls.dat_sect) begin
                  add_en   = 1'b1;
                  win_load = 1'b1;
               end else begin
                  nxt = ST_READ;
               end
            end else if (win_expire) begin
               go    = 1'b1;
               go_op = OP_SECT;
               nxt   = ST_BUSY;
            end
         end
         ST_BUSY: if (eng_done) nxt = ST_READ;
         default: nxt = ST_READ;
      endcase
   end

   assign clr     = (nxt == ST_READ);
   assign win_run = (st_q == ST_WIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_READ;
         start_req_q <= 1'b0;
         op_q        <= OP_NONE;
         pg_addr_q   <= '0;
         pg_data_q   <= '0;
      end else begin
         st_q        <= nxt;
         start_req_q <= go;
         if (go) op_q <= go_op;
         if (cap_pgm) begin
            pg_addr_q <= wr_addr;
            pg_data_q <= wr_data;
         end
      end
   end

   p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_req_q |=> !start_req_q);

   p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_req_q |-> (st_q == ST_BUSY));

   p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BUSY) |=> !start_req_q);

   p_done_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_BUSY) && eng_done) |=> (st_q == ST_READ));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W    = 18,
   parameter int NUM_SECT  = 8,
   parameter int WIN_CYC   = 2500,
   parameter bit RISE_EDGE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [7:0]          bus_data,
   input  logic                bus_we_n,
   input  logic                eng_done,
   output logic                read_mode,
   output logic                eng_start,
   output logic [1:0]          start_op,
   output logic [NUM_SECT-1:0] start_sect_map,
   output logic [ADDR_W-1:0]   start_addr,
   output logic [7:0]          start_data
);
   localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
   localparam int CMP_W  = 11;

   generate
      if (NUM_SECT < 2 || NUM_SECT != (1 << SECT_W)) begin : g_bad_sect
         $error("flash_cmd_decoder: NUM_SECT must be a power of two >= 2");
      end
      if (WIN_CYC < 2) begin : g_bad_win
         $error("flash_cmd_decoder: WIN_CYC must be at least 2");
      end
      if (ADDR_W < CMP_W || ADDR_W < SECT_W) begin : g_bad_addr
         $error("flash_cmd_decoder: ADDR_W too small");
      end
   endgenerate

   logic       wr_evt;
   cyc_class_t cls;
   fst_e       st;
   fop_e       op;
   logic       clr, set_all, add_en, win_load, win_run, win_expire;

   fcd_wr_strobe #(.RISE_EDGE(RISE_EDGE)) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_we_n (bus_we_n),
      .wr_evt   (wr_evt)
   );

   fcd_classify #(.CMP_W(CMP_W)) u_cls (
      .cmp_addr (bus_addr[CMP_W-1:0]),
      .wr_data  (bus_data),
      .cls      (cls)
   );

   fcd_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_evt      (wr_evt),
      .cls         (cls),
      .wr_addr     (bus_addr),
      .wr_data     (bus_data),
      .eng_done    (eng_done),
      .win_expire  (win_expire),
      .st_q        (st),
      .clr         (clr),
      .set_all     (set_all),
      .add_en      (add_en),
      .win_load    (win_load),
      .win_run     (win_run),
      .start_req_q (eng_start),
      .op_q        (op),
      .pg_addr_q   (start_addr),
      .pg_data_q   (start_data)
   );

   fcd_sector_buf #(
      .NUM_SECT (NUM_SECT),
      .SECT_W   (SECT_W),
      .WIN_CYC  (WIN_CYC)
   ) u_sbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .set_all    (set_all),
      .add_en     (add_en),
      .add_idx    (bus_addr[ADDR_W-1 -: SECT_W]),
      .win_load   (win_load),
      .win_run    (win_run),
      .map        (start_sect_map),
      .win_expire (win_expire)
   );

   assign read_mode = (st == ST_READ);
   assign start_op  = op;

   p_idle_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      read_mode |-> (start_sect_map == '0));

   p_chip_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && start_op == 2'd2) |-> (&start_sect_map));

   p_sect_some_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && start_op == 2'd3) |-> (|start_sect_map));

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
   localparam int WIN = 2500;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [17:0] bus_addr = '0;
   logic [7:0]  bus_data = '0;
   logic        bus_we_n = 1'b1;
   logic        eng_done = 1'b0;
   logic        read_mode, eng_start;
   logic [1:0]  start_op;
   logic [7:0]  start_sect_map;
   logic [17:0] start_addr;
   logic [7:0]  start_data;

   int    total = 0, bad = 0, cyc = 0, n_starts = 0;
   bit    ended = 0;
   string tag = "R1";

   always #10 clk = ~clk;

   flash_cmd_decoder #(.WIN_CYC(WIN)) i_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_we_n(bus_we_n), .eng_done(eng_done), .read_mode(read_mode),
      .eng_start(eng_start), .start_op(start_op), .start_sect_map(start_sect_map),
      .start_addr(start_addr), .start_data(start_data)
   );

   // behavioural reference: step 0 read, 1..5 prefix, 6 program wait, 7 window, 8 engine running
   int       m_step = 0, m_win = 0;
   bit       m_we_prev = 1, m_start = 0;
   int       m_op = 0;
   bit [7:0] m_map = 0;
   bit [17:0] m_addr = 0;
   bit [7:0]  m_data = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_step = 0; m_win = 0; m_we_prev = 1; m_start = 0; m_op = 0;
         m_map = 0; m_addr = 0; m_data = 0;
      end else begin
         bit ev, ka, kb, at5;
         ev  = bus_we_n && !m_we_prev;
         m_we_prev = bus_we_n;
         m_start = 0;
         at5 = (bus_addr[10:0] == 11'h555);
         ka  = at5 && bus_data == 8'hAA;
         kb  = (bus_addr[10:0] == 11'h2AA) && bus_data == 8'h55;
         if (m_step == 8) begin
            if (eng_done) m_step = 0;
         end else if (ev) begin
            case (m_step)
               0: m_step = ka ? 1 : 0;
               1: m_step = kb ? 2 : 0;
               2: m_step = (at5 && bus_data == 8'h80) ? 3 : (at5 && bus_data == 8'hA0) ? 6 : 0;
               3: m_step = ka ? 4 : 0;
               4: m_step = kb ? 5 : 0;
               5: if (at5 && bus_data == 8'h10) begin
                     m_map = 8'hFF; m_start = 1; m_op = 2; m_step = 8;
                  end else if (bus_data == 8'h30) begin
                     m_map[bus_addr[17:15]] = 1'b1; m_win = WIN - 1; m_step = 7;
                  end else m_step = 0;
               6: begin
                  m_addr = bus_addr; m_data = bus_data; m_start = 1; m_op = 1; m_step = 8;
               end
               7: if (bus_data == 8'h30) begin
                     m_map[bus_addr[17:15]] = 1'b1; m_win = WIN - 1;
                  end else m_step = 0;
               default: m_step = 0;
            endcase
         end else if (m_step == 7) begin
            if (m_win == 0) begin m_start = 1; m_op = 3; m_step = 8; end
            else m_win = m_win - 1;
         end
         if (m_step == 0) m_map = 0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !ended) begin
         chk(eng_start == m_start, tag, "eng_start", eng_start, m_start);
         chk(read_mode == (m_step == 0), tag, "read_mode", read_mode, m_step == 0);
         chk(start_sect_map == m_map, tag, "sect_map", start_sect_map, m_map);
         if (m_start) begin
            chk(start_op == m_op[1:0], tag, "start_op", start_op, m_op);
            if (m_op == 1) begin
               chk(start_addr == m_addr, tag, "start_addr", start_addr, m_addr);
               chk(start_data == m_data, tag, "start_data", start_data, m_data);
            end
         end
         if (eng_start) n_starts++;
      end
   end

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !ended) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
         summary();
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [17:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_data = d; bus_we_n = 1'b0;
      @(negedge clk); bus_we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic erase_prefix(input logic [17:0] hi);
      wr(hi | 18'h555, 8'hAA); wr(hi | 18'h2AA, 8'h55); wr(18'h555, 8'h80);
      wr(18'h555, 8'hAA); wr(18'h2AA, 8'h55);
   endtask

   task automatic finish_engine();
      idle(4);
      @(negedge clk); eng_done = 1'b1;
      @(negedge clk); eng_done = 1'b0;
      idle(2);
   endtask

   task automatic starts_is(input string req, input int exp);
      chk(n_starts == exp, req, "start count", n_starts, exp);
      n_starts = 0;
   endtask

   initial begin
      idle(3);
      // R1 reset state
      chk(read_mode == 1'b1 && eng_start == 1'b0 && start_sect_map == 8'h00, "R1", "reset outputs",
          {read_mode, eng_start, start_sect_map}, 10'h200);
      @(negedge clk); rst_n = 1'b1;
      idle(3);

      // R2 chip erase, then R7 writes ignored while engine runs
      tag = "R2"; erase_prefix(18'h0); wr(18'h555, 8'h10); idle(2);
      starts_is("R2", 1);
      tag = "R7"; erase_prefix(18'h0); wr(18'h555, 8'h10);
      chk(read_mode == 1'b0, "R7", "busy read_mode", read_mode, 0);
      starts_is("R7", 0);
      finish_engine();
      chk(read_mode == 1'b1, "R7", "read after done", read_mode, 1);

      // R2 with upper address bits set on the unlock writes
      tag = "R2"; erase_prefix(18'h38000); wr(18'h555, 8'h10); finish_engine();
      starts_is("R2", 1);

      // R3 single sector
      tag = "R3"; erase_prefix(18'h0); wr(18'd5 << 15, 8'h30);
      idle(WIN - 10);
      starts_is("R3", 0);
      idle(20); starts_is("R3", 1);
      finish_engine();

      // R4/R5 window extension with duplicate sector
      tag = "R4"; erase_prefix(18'h0); wr(18'd2 << 15, 8'h30);
      wr(18'd6 << 15, 8'h30);
      tag = "R5"; wr((18'd2 << 15) | 18'h123, 8'h30); wr(18'd0, 8'h30);
      tag = "R4"; idle(WIN + 5);
      starts_is("R4", 1);
      finish_engine();

      // R6 mismatches
      tag = "R6"; wr(18'h555, 8'hAA); wr(18'h2AA, 8'h55); wr(18'h555, 8'h90);
      chk(read_mode == 1'b1, "R6", "bad setup", read_mode, 1);
      erase_prefix(18'h0); wr(18'd3 << 15, 8'h30); idle(10); wr(18'h555, 8'hF0);
      chk(start_sect_map == 8'h00, "R6", "window abort map", start_sect_map, 0);
      idle(WIN + 5); starts_is("R6", 0);
      wr(18'h2AA, 8'hAA); idle(2); starts_is("R6", 0);

      // R9 program
      tag = "R9"; wr(18'h555, 8'hAA); wr(18'h2AA, 8'h55); wr(18'h555, 8'hA0);
      wr(18'h1234A, 8'h5C); idle(2); starts_is("R9", 1);
      finish_engine();

      // R8 reset in window and during engine run
      tag = "R8"; erase_prefix(18'h0); wr(18'd4 << 15, 8'h30); idle(50);
      @(negedge clk); rst_n = 1'b0; @(negedge clk);
      chk(read_mode == 1'b1 && start_sect_map == 8'h00, "R8", "reset in window",
          {read_mode, start_sect_map}, 9'h100);
      rst_n = 1'b1; idle(WIN + 5); starts_is("R8", 0);
      erase_prefix(18'h0); wr(18'h555, 8'h10); idle(3);
      @(negedge clk); rst_n = 1'b0; @(negedge clk);
      chk(read_mode == 1'b1 && eng_start == 1'b0, "R8", "reset in busy",
          {read_mode, eng_start}, 2'b10);
      rst_n = 1'b1; idle(5);
      starts_is("R8", 1);

      // R10 pulse width covered per cycle; one more program for the tag
      tag = "R10"; wr(18'h555, 8'hAA); wr(18'h2AA, 8'h55); wr(18'h555, 8'hA0);
      wr(18'h00001, 8'hFE); idle(4); starts_is("R10", 1);
      finish_engine();
      summary();
   end

endmodule